// File: doc/BRIEF.md
# Indexed and Direct-Color Pixel Unpacker

This block sits between a frame-data FIFO and a TFT-style pixel path. It takes 32-bit words of display data over a valid/ready handshake and produces one 24-bit RGB pixel per accepted output transfer. In the indexed modes each word is split into 1, 2, 4 or 8-bit palette indices, taken in one of three orderings. Each index selects an entry of an on-chip 256 x 16-bit colour table. In the direct modes each word carries either two 16-bit 5:6:5 pixels or one 24-bit pixel, and the table is not used.

A host loads the colour table through a simple write port, which may be used at any time. The mode and ordering inputs are sampled when a word is accepted, so they may change while that word is still being unpacked. All 16-bit colours, from the table or direct, are widened to 8:8:8 by copying the top bits of each channel into the vacated low bits.

Top module: `pix_unpacker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pix_valid` is 0 and `in_ready` is 1.
- R2: `cfg_mode` codes give the pixels per word: 0 = 1 bpp (32), 1 = 2 bpp (16), 2 = 4 bpp (8), 3 = 8 bpp (4), 4 = 16 bpp direct (2), 5 = 24 bpp direct (1); codes 6 and 7 act as 8 bpp. No pixel is emitted that was not produced by an accepted word.
- R3: `cfg_order` 0 (and the unused code 3) is little-endian: pixel k of an indexed word is bits [k*b +: b], where b is the bits per pixel.
- R4: `cfg_order` 1 is big-endian: pixel k is bits [32-(k+1)*b +: b], so the first pixel is the top of byte 3; in 16 bpp the first pixel is bits [31:16].
- R5: `cfg_order` 2 is mixed: bytes are taken from byte 0 upward, and inside each byte indices are taken from the most significant end first; at 8 and 16 bpp it equals little-endian.
- R6: An index selects a 16-bit table entry written through `pal_we`/`pal_addr`/`pal_wdata`. The entry is read as R[15:11], G[10:5], B[4:0] and output as `pix_rgb` = {R8, G8, B8}, each channel extended by repeating its top bits.
- R7: Mode 4 bypasses the table; each 16-bit half is widened from 5:6:5 exactly as in R6.
- R8: Mode 5 bypasses the table and emits `in_data[23:0]` unchanged as the single pixel of the word.
- R9: A new word is accepted only in the cycle in which the last pixel of the current word enters the output pipeline, or when no word is held. Mode and ordering are taken from the cycle of acceptance.
- R10: With `pix_ready` held high and the pipeline empty, the first pixel of a word accepted at clock edge E is valid after edge E+2. The remaining pixels follow on consecutive cycles.
- R11: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_rgb` does not change.
- R12: A table write to the entry being read at the same clock edge does not affect that read; the pixel carries the entry's previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word available |
| in_data | input | 32 | Input display word |
| in_ready | output | 1 | Block can take a word this cycle |
| cfg_mode | input | 3 | Pixel depth code (see R2) |
| cfg_order | input | 2 | Pixel ordering code (see R3 to R5) |
| pal_we | input | 1 | Colour table write strobe |
| pal_addr | input | 8 | Colour table write address |
| pal_wdata | input | 16 | Colour table write data, 5:6:5 |
| pix_valid | output | 1 | Output pixel available |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_rgb | output | 24 | Pixel, red in [23:16], blue in [7:0] |

## Verification
A word accepted at one edge has its first pixel in the table-read stage after the next edge, and on the outputs after the edge after that. Each further pixel follows one cycle later unless `pix_ready` stalls it. A table write lands at the same edge as the read it races, so the bench times the colliding write to the first edge after acceptance. The bench drives inputs 2 ns after each rising edge and samples everything on the falling edge. A reference queue is filled as each word is accepted and compared against every completed output transfer, alongside direct cycle counts for the latency, the stall limit and the held output.

// File: rtl/pu_pkg.sv
package pu_pkg;

  localparam int WORD_W    = 32;
  localparam int RGB_W     = 24;
  localparam int PAL_W     = 16;
  localparam int PAL_DEPTH = 256;
  localparam int IDX_W     = $clog2(PAL_DEPTH);

  typedef enum logic [2:0] {
    MODE_1BPP  = 3'd0,
    MODE_2BPP  = 3'd1,
    MODE_4BPP  = 3'd2,
    MODE_8BPP  = 3'd3,
    MODE_16BPP = 3'd4,
    MODE_24BPP = 3'd5
  } pu_mode_e;

  typedef enum logic [1:0] {
    ORD_LITTLE = 2'd0,
    ORD_BIG    = 2'd1,
    ORD_MIXED  = 2'd2
  } pu_order_e;

  function automatic logic [5:0] bits_per_pix(input logic [2:0] m);
    case (m)
      MODE_1BPP:  bits_per_pix = 6'd1;
      MODE_2BPP:  bits_per_pix = 6'd2;
      MODE_4BPP:  bits_per_pix = 6'd4;
      MODE_16BPP: bits_per_pix = 6'd16;
      MODE_24BPP: bits_per_pix = 6'd24;
      default:    bits_per_pix = 6'd8;
    endcase
  endfunction

  function automatic logic [5:0] pix_per_word(input logic [2:0] m);
    case (m)
      MODE_1BPP:  pix_per_word = 6'd32;
      MODE_2BPP:  pix_per_word = 6'd16;
      MODE_4BPP:  pix_per_word = 6'd8;
      MODE_16BPP: pix_per_word = 6'd2;
      MODE_24BPP: pix_per_word = 6'd1;
      default:    pix_per_word = 6'd4;
    endcase
  endfunction

  // 5:6:5 to 8:8:8, top bits of each channel refill its low bits
  function automatic logic [23:0] widen565(input logic [15:0] p);
    widen565 = {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction

endpackage

// File: rtl/pu_slicer.sv
module pu_slicer
  import pu_pkg::*;
#(
  parameter int W_WORD = WORD_W,
  parameter int W_IDX  = IDX_W,
  parameter int W_RGB  = RGB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W_WORD-1:0] in_data,
  output logic              in_ready,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_order,
  input  logic              s_take,
  output logic              s_valid,
  output logic              s_direct,
  output logic [W_IDX-1:0]  s_index,
  output logic [W_RGB-1:0]  s_pixel
);
  localparam int CNT_W = $clog2(W_WORD);
  localparam int SH_W  = CNT_W + 6;

  logic              have_q;
  logic [W_WORD-1:0] word_q;
  logic [2:0]        mode_q;
  logic [1:0]        ord_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [5:0]        bpp;
  logic              last;
  logic [SH_W-1:0]   ib, sh;
  logic [15:0]       low;
  logic [W_IDX-1:0]  mask;

  always_comb begin
    bpp  = bits_per_pix(mode_q);
    last = (6'(cnt_q) == pix_per_word(mode_q) - 6'd1);
    ib   = SH_W'(cnt_q) * SH_W'(bpp);
    case (pu_order_e'(ord_q))
      ORD_BIG:   sh = SH_W'(W_WORD) - ib - SH_W'(bpp);
      ORD_MIXED: sh = (bpp < 6'd8) ? ((ib & ~SH_W'(7)) + SH_W'(8) - SH_W'(bpp) - (ib & SH_W'(7)))
                                   : ib;
      default:   sh = ib;
    endcase
    if (mode_q == MODE_24BPP) sh = '0;
    low = 16'(word_q >> sh);
    case (pu_mode_e'(mode_q))
      MODE_1BPP: mask = W_IDX'(8'h01);
      MODE_2BPP: mask = W_IDX'(8'h03);
      MODE_4BPP: mask = W_IDX'(8'h0F);
      default:   mask = '1;
    endcase
    s_index  = low[W_IDX-1:0] & mask;
    s_direct = (mode_q == MODE_16BPP) || (mode_q == MODE_24BPP);
    s_pixel  = (mode_q == MODE_24BPP) ? W_RGB'(word_q) : W_RGB'(widen565(low));
    s_valid  = have_q;
    in_ready = !have_q || (s_take && last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (in_valid && in_ready) begin
      have_q <= 1'b1;
      cnt_q  <= '0;
    end else if (have_q && s_take) begin
      if (last) have_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      word_q <= in_data;
      mode_q <= cfg_mode;
      ord_q  <= cfg_order;
    end
  end

endmodule

// File: rtl/pu_palette.sv
module pu_palette #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first: a same-edge write is not seen by the read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/pu_outpipe.sv
module pu_outpipe
  import pu_pkg::*;
#(
  parameter int W_RGB = RGB_W,
  parameter int W_PAL = PAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic             s_direct,
  input  logic [W_RGB-1:0] s_pixel,
  input  logic [W_PAL-1:0] pal_q,
  output logic             adv_b,
  input  logic             pix_ready,
  output logic             pix_valid,
  output logic [W_RGB-1:0] pix_rgb
);
  logic             b_valid, b_direct, c_valid;
  logic [W_RGB-1:0] b_pix;
  logic             adv_c;

  always_comb begin
    adv_c     = !c_valid || pix_ready;
    adv_b     = !b_valid || adv_c;
    pix_valid = c_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      c_valid <= 1'b0;
    end else begin
      if (adv_b) b_valid <= s_valid;
      if (adv_c) c_valid <= b_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv_b) begin
      b_direct <= s_direct;
      b_pix    <= s_pixel;
    end
    if (adv_c) pix_rgb <= b_direct ? b_pix : W_RGB'(widen565(16'(pal_q)));
  end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pu_pkg::*;
#(
  parameter int W_WORD  = WORD_W,
  parameter int W_RGB   = RGB_W,
  parameter int W_PAL   = PAL_W,
  parameter int N_PAL   = PAL_DEPTH,
  parameter int W_PADDR = $clog2(N_PAL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [W_WORD-1:0]  in_data,
  output logic               in_ready,
  input  logic [2:0]         cfg_mode,
  input  logic [1:0]         cfg_order,
  input  logic               pal_we,
  input  logic [W_PADDR-1:0] pal_addr,
  input  logic [W_PAL-1:0]   pal_wdata,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [W_RGB-1:0]   pix_rgb
);
  logic               s_valid, s_direct, adv_b;
  logic [W_PADDR-1:0] s_index;
  logic [W_RGB-1:0]   s_pixel;
  logic [W_PAL-1:0]   pal_q;

  pu_slicer #(.W_WORD(W_WORD), .W_IDX(W_PADDR), .W_RGB(W_RGB)) u_slicer (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_mode(cfg_mode), .cfg_order(cfg_order),
    .s_take(adv_b), .s_valid(s_valid), .s_direct(s_direct),
    .s_index(s_index), .s_pixel(s_pixel)
  );

  pu_palette #(.DEPTH(N_PAL), .DW(W_PAL), .AW(W_PADDR)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_wdata),
    .re(adv_b), .raddr(s_index), .rdata(pal_q)
  );

  pu_outpipe #(.W_RGB(W_RGB), .W_PAL(W_PAL)) u_out (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_direct(s_direct), .s_pixel(s_pixel),
    .pal_q(pal_q), .adv_b(adv_b),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
  );

endmodule

// File: rtl/pu_checks.sv
module pu_checks
  import pu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  cfg_mode,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [23:0] pix_rgb
);
  logic [15:0] pend;
  logic        acc, emit;

  assign acc  = in_valid && in_ready;
  assign emit = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + (acc ? 16'(pix_per_word(cfg_mode)) : 16'd0) - (emit ? 16'd1 : 16'd0);
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (!pix_valid && in_ready));

  assert_no_excess_R2: assert property (@(posedge clk) disable iff (rst)
    emit |-> (pend != 16'd0));

  // at most the last slice plus two pipeline stages are owed when a word is taken
  assert_word_gate_R9: assert property (@(posedge clk) disable iff (rst)
    acc |-> (pend <= 16'd3));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_rgb)));

  assert_known_R6: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> !$isunknown(pix_rgb));

endmodule

bind pix_unpacker pu_checks u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_mode(cfg_mode), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_rgb(pix_rgb)
);

// File: tb/pix_unpacker_test.sv
module pix_unpacker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [2:0]  cfg_mode = '0;
  logic [1:0]  cfg_order = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [15:0] pal_wdata = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [23:0] pix_rgb;

  always #5 clk = ~clk;

  pix_unpacker uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_mode(cfg_mode), .cfg_order(cfg_order), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_rgb(pix_rgb)
  );

  int total = 0, bad = 0, cyc = 0;
  int acc_cnt = 0, out_cnt = 0, push_cnt = 0, acc_cyc = 0, first_out = -1;
  int rdy_mode = 0;
  logic [15:0] pal_m [256];
  logic [23:0] exp_q [$];
  string       tag_q [$];
  bit          held = 0;
  logic [23:0] held_rgb;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] grow(input logic [15:0] p);
    int r, g, b;
    r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
    return 24'(((r * 8 + r / 4) << 16) | ((g * 4 + g / 16) << 8) | (b * 8 + b / 4));
  endfunction

  task automatic push_word(input logic [31:0] w, input int m, input int o);
    if (m == 5) begin
      exp_q.push_back(w[23:0]); tag_q.push_back("R8"); push_cnt++;
    end else if (m == 4) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] h;
        h = (o == 1) ? 16'(w >> (16 - 16 * k)) : 16'(w >> (16 * k));
        exp_q.push_back(grow(h)); tag_q.push_back("R7"); push_cnt++;
      end
    end else begin
      int b, msk;
      logic [31:0] sw;
      b = (m <= 3) ? (1 << m) : 8;
      msk = (1 << b) - 1;
      sw = {w[7:0], w[15:8], w[23:16], w[31:24]};
      for (int k = 0; k < 32 / b; k++) begin
        int idx;
        if (o == 1)                idx = int'(w >> (32 - (k + 1) * b)) & msk;
        else if (o == 2 && b < 8)  idx = int'(sw >> (32 - (k + 1) * b)) & msk;
        else                       idx = int'(w >> (k * b)) & msk;
        exp_q.push_back(grow(pal_m[idx]));
        tag_q.push_back(o == 1 ? "R4" : (o == 2 ? "R5" : "R3"));
        push_cnt++;
      end
    end
  endtask

  // monitor: falling edge, results of the previous rising edge are settled
  always @(negedge clk) begin
    if (!rst) begin
      if (held) chk(pix_valid && pix_rgb == held_rgb, "R11", pix_rgb, held_rgb);
      held = pix_valid && !pix_ready;
      held_rgb = pix_rgb;
      if (pix_valid && first_out < 0) first_out = cyc;
      if (pix_valid && pix_ready) begin
        out_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R2", pix_rgb, 0);
        else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(pix_rgb == e, t, pix_rgb, e);
        end
      end
      if (in_valid && in_ready) begin
        push_word(in_data, int'(cfg_mode), int'(cfg_order));
        acc_cnt++;
        acc_cyc = cyc + 1;
      end
      if (pal_we) pal_m[pal_addr] = pal_wdata;
    end
  end

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: pix_ready = 1'b1;
      1: pix_ready = ($urandom_range(0, 2) != 0);
      default: pix_ready = 1'b0;
    endcase
  end

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic send(input logic [31:0] w, input int m, input int o);
    cfg_mode = 3'(m); cfg_order = 2'(o); in_data = w; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic pal_write(input int a, input logic [15:0] d);
    pal_we = 1'b1; pal_addr = 8'(a); pal_wdata = d;
    tick;
    pal_we = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while ((exp_q.size() != 0 || pix_valid) && n < 3000) begin tick; n++; end
    tick; tick;
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    @(negedge clk);
    chk(!pix_valid, "R1", pix_valid, 0);
    chk(in_ready, "R1", in_ready, 1);
    @(posedge clk); #2; rst = 1'b0;
    @(negedge clk);
    chk(!pix_valid && in_ready, "R1", {pix_valid, in_ready}, 2'b01);

    // R6: load every table entry
    for (int i = 0; i < 256; i++) pal_write(i, 16'((i * 40503) ^ 16'hA5C3));

    // orderings x depths, config scrambled right after each acceptance (R9)
    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 7; m++)
        for (int r = 0; r < 2; r++) begin
          send($urandom, m, o);
          cfg_mode = 3'($urandom); cfg_order = 2'($urandom);
        end
    drain;

    // R10: latency and back-to-back pixels
    first_out = -1;
    send(32'h00C0FFEE, 5, 0);
    repeat (4) tick;
    chk(first_out - acc_cyc == 2, "R10", first_out - acc_cyc, 2);
    drain;
    begin
      int n = 0, f = -1, l = -1;
      send(32'h1234ABCD, 3, 0);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (pix_valid) begin n++; if (f < 0) f = cyc; l = cyc; end
      end
      chk(n == 4, "R10", n, 4);
      chk(l - f == 3, "R10", l - f, 3);
    end
    drain;

    // R9: stalled output limits accepted words
    begin
      int base;
      rdy_mode = 2; tick;
      base = acc_cnt;
      cfg_mode = 3'd5; cfg_order = 2'd0; in_valid = 1'b1;
      for (int i = 0; i < 12; i++) begin in_data = 32'h00AB0000 + 32'(i); tick; end
      in_valid = 1'b0;
      @(negedge clk);
      chk(acc_cnt - base == 3, "R9", acc_cnt - base, 3);
      chk(!in_ready, "R9", in_ready, 0);
      rdy_mode = 0; drain;
      rdy_mode = 2; tick;
      base = acc_cnt;
      cfg_mode = 3'd3; cfg_order = 2'd1; in_valid = 1'b1;
      for (int i = 0; i < 12; i++) begin in_data = 32'h5A000000 + 32'(i * 977); tick; end
      in_valid = 1'b0;
      @(negedge clk);
      chk(acc_cnt - base == 1, "R9", acc_cnt - base, 1);
      rdy_mode = 0; drain;
    end

    // R11: random backpressure over mixed traffic
    rdy_mode = 1;
    for (int i = 0; i < 24; i++) send($urandom, int'($urandom_range(0, 5)), int'($urandom_range(0, 2)));
    drain;
    rdy_mode = 0;
    drain;

    // R12: write racing the read of the same entry
    pal_write(5, 16'hF800);
    pal_write(6, 16'h07E0);
    tick;
    send(32'h06060605, 3, 0);
    pal_we = 1'b1; pal_addr = 8'd5; pal_wdata = 16'h001F;
    tick;
    pal_we = 1'b0;
    @(negedge clk);
    while (!pix_valid) @(negedge clk);
    chk(pix_rgb == 24'hFF0000, "R12", pix_rgb, 24'hFF0000);
    drain;
    send(32'h05050505, 3, 2);
    @(negedge clk);
    while (!pix_valid) @(negedge clk);
    chk(pix_rgb == 24'h0000FF, "R6", pix_rgb, 24'h0000FF);
    drain;

    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    chk(out_cnt == push_cnt, "R2", out_cnt, push_cnt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule